// File: doc/BRIEF.md
# Dual-Clock FIFO with Fall-Through Timing Mode

This block is a first-in first-out store that links two unrelated clock domains. A producer writes words on its own clock, and a consumer reads them on a second clock. That second clock may be unrelated to the first or may be the same clock. Each port has an active-low select and an active-high enable. A word moves only on a rising edge of that port's clock when both of them are asserted. The write and read pointers cross between the domains as gray code through two-flop synchronisers. A single asynchronous reset is released into each domain through its own synchroniser.

The read side runs in one of two timing modes. The `mode_std` pin chooses the mode, and the block captures the pin on the first read-clock cycle after reset. In standard mode, `rd_flag` means the store holds data, and a word reaches `rd_data` on the read edge that takes it. In fall-through mode, an output register preloads the oldest word. `rd_flag` then means that word is already on `rd_data`, and each read replaces it with the next word. The output register is one more place to hold a word, so the block holds DEPTH+1 words in this mode.

Read FSM states: `RD_INIT` (captures the mode), `RD_STD` (standard), `RD_FT_WAIT` (fall-through, output register empty) and `RD_FT_HOLD` (fall-through, word presented). Its transitions are:
- `RD_INIT` goes to `RD_STD` when `mode_std` is 1, and to `RD_FT_WAIT` when it is 0.
- `RD_FT_WAIT` goes to `RD_FT_HOLD` when the store is not empty.
- `RD_FT_HOLD` goes to `RD_FT_WAIT` on a read that finds the store empty.
- `RD_STD` is terminal until reset.

Write FSM states: `WS_BOOT`, `WS_OPEN` and `WS_FULL`. After `WS_BOOT`, each edge moves the write FSM to `WS_FULL` when the next write pointer equals the full pattern, and to `WS_OPEN` otherwise.

Top module: `xdom_fifo`

## Requirements
- R1: A transfer occurs only on a rising edge of that port's clock with its `*_cs_n` at 0 and its `*_en` at 1. Any other combination leaves the pointers, the flags and `rd_data` unchanged.
- R2: `wr_flag` is a write-clock register. It is 1 when a write will be accepted and 0 when the store is full. It is 0 in reset and rises one write-clock edge after the reset is released into the write domain.
- R3: In standard mode, `rd_flag` is a read-clock register that is 1 exactly when the store holds at least one unread word.
- R4: The mode is captured on the first read-clock edge after reset: 1 selects standard mode and 0 selects fall-through mode. Changes on `mode_std` after that edge have no effect until the next reset.
- R5: In fall-through mode, `rd_flag` at 1 means `rd_data` already holds the oldest word, with no read needed. A read consumes that word and presents the next one on the same edge, or clears `rd_flag` if none remains.
- R6: In standard mode, `rd_data` is loaded with the oldest word on the edge of an accepted read, and it holds its value on every other edge.
- R7: Words leave in the order they were written, in both modes.
- R8: A write while `wr_flag` is 0 stores nothing and leaves the write pointer unchanged.
- R9: A read while `rd_flag` is 0 has no effect: `rd_data` and the read pointer are unchanged.
- R10: Capacity is DEPTH words in standard mode and DEPTH+1 words in fall-through mode.
- R11: While reset is asserted, `wr_flag` and `rd_flag` are 0 and `rd_data` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| mode_std | input | 1 | Timing mode, captured after reset: 1 standard, 0 fall-through |
| wr_clk | input | 1 | Write-side clock |
| wr_cs_n | input | 1 | Write port select, active low |
| wr_en | input | 1 | Write port enable, active high |
| wr_data | input | WIDTH | Word to store |
| wr_flag | output | 1 | Space available (not full / input ready) |
| rd_clk | input | 1 | Read-side clock |
| rd_cs_n | input | 1 | Read port select, active low |
| rd_en | input | 1 | Read port enable, active high |
| rd_data | output | WIDTH | Output word |
| rd_flag | output | 1 | Standard: not empty. Fall-through: `rd_data` valid |

## Verification
Some results are due in the same domain as their stimulus. A standard read updates `rd_data` on the read edge. `wr_flag` falls on the write edge that fills the last place, and it rises one edge after the reset is released into the write domain. Other results cross between the domains. A write shows up in `rd_flag` three read-clock edges later in standard mode: two synchroniser stages and the registered empty flag. In fall-through mode it takes four edges, because the output register load adds one. A read frees a place in `wr_flag` three write-clock edges later. The bench samples every same-domain result at the falling edge that follows its causing edge. For every cross-domain result it waits at least eight read-clock and eight write-clock cycles before sampling, which covers the worst case of the two unrelated clocks.

// File: rtl/xdom_fifo_pkg.sv
package xdom_fifo_pkg;

    typedef enum logic [1:0] {
        WS_BOOT = 2'd0,
        WS_OPEN = 2'd1,
        WS_FULL = 2'd2
    } wr_state_e;

    typedef enum logic [1:0] {
        RD_INIT    = 2'd0,
        RD_STD     = 2'd1,
        RD_FT_WAIT = 2'd2,
        RD_FT_HOLD = 2'd3
    } rd_state_e;

    function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

endpackage

// File: rtl/xdom_fifo_rstsync.sv
module xdom_fifo_rstsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic srst_n
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain <= '0;
        else         chain <= {chain[STAGES-2:0], 1'b1};
    end

    assign srst_n = chain[STAGES-1];
endmodule

// File: rtl/xdom_fifo_gsync.sv
module xdom_fifo_gsync #(
    parameter int W      = 12,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[0] <= '0;
        else        pipe[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[s] <= '0;
            else        pipe[s] <= pipe[s-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/xdom_fifo_ram.sv
module xdom_fifo_ram #(
    parameter int AW    = 11,
    parameter int WIDTH = 36
) (
    input  logic             wclk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    localparam int NWORDS = 1 << AW;

    logic [WIDTH-1:0] store [NWORDS];

    always_ff @(posedge wclk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/xdom_fifo_wside.sv
module xdom_fifo_wside
    import xdom_fifo_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fire,
    input  logic [AW:0] rgray_s,
    output logic        push,
    output logic [AW:0] wbin,
    output logic [AW:0] wgray,
    output logic        wr_ok
);
    localparam int PW = AW + 1;

    wr_state_e  state_q, state_d;
    logic [AW:0] wbin_nx, wgray_nx, full_pat;
    logic        full_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WS_BOOT;
        else        state_q <= state_d;
    end

    always_comb begin
        push     = fire && (state_q == WS_OPEN);
        wbin_nx  = wbin + PW'(push);
        wgray_nx = PW'(bin_to_gray(32'(wbin_nx)));
        full_pat = {~rgray_s[AW:AW-1], rgray_s[AW-2:0]};
        full_nx  = (wgray_nx == full_pat);
        unique case (state_q)
            WS_BOOT: state_d = WS_OPEN;
            WS_OPEN: state_d = full_nx ? WS_FULL : WS_OPEN;
            WS_FULL: state_d = full_nx ? WS_FULL : WS_OPEN;
            default: state_d = WS_BOOT;
        endcase
        wr_ok = (state_q == WS_OPEN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else begin
            wbin  <= wbin_nx;
            wgray <= wgray_nx;
        end
    end
endmodule

// File: rtl/xdom_fifo_rside.sv
module xdom_fifo_rside
    import xdom_fifo_pkg::*;
#(
    parameter int AW    = 11,
    parameter int WIDTH = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_std,
    input  logic             fire,
    input  logic [AW:0]      wgray_s,
    input  logic [WIDTH-1:0] head_word,
    output logic [AW:0]      rbin,
    output logic [AW:0]      rgray,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_ok,
    output logic             is_std,
    output logic             mode_known
);
    localparam int PW = AW + 1;

    rd_state_e   state_q, state_d;
    logic        empty_q;
    logic        take;
    logic [AW:0] rbin_nx, rgray_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_INIT;
        else        state_q <= state_d;
    end

    always_comb begin
        take    = 1'b0;
        state_d = state_q;
        unique case (state_q)
            RD_INIT: begin
                state_d = mode_std ? RD_STD : RD_FT_WAIT;
            end
            RD_STD: begin
                take = fire && !empty_q;
            end
            RD_FT_WAIT: begin
                take = !empty_q;
                if (!empty_q) state_d = RD_FT_HOLD;
            end
            RD_FT_HOLD: begin
                take = fire && !empty_q;
                if (fire && empty_q) state_d = RD_FT_WAIT;
            end
            default: state_d = RD_INIT;
        endcase
        rbin_nx  = rbin + PW'(take);
        rgray_nx = PW'(bin_to_gray(32'(rbin_nx)));
    end

    always_comb begin
        rd_ok      = 1'b0;
        is_std     = 1'b0;
        mode_known = 1'b1;
        unique case (state_q)
            RD_INIT:    mode_known = 1'b0;
            RD_STD:     begin is_std = 1'b1; rd_ok = !empty_q; end
            RD_FT_WAIT: rd_ok = 1'b0;
            RD_FT_HOLD: rd_ok = 1'b1;
            default:    mode_known = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rbin    <= '0;
            rgray   <= '0;
            empty_q <= 1'b1;
            rd_data <= '0;
        end else begin
            rbin    <= rbin_nx;
            rgray   <= rgray_nx;
            empty_q <= (rgray_nx == wgray_s);
            if (take) rd_data <= head_word;
        end
    end
endmodule

// File: rtl/xdom_fifo.sv
module xdom_fifo #(
    parameter int DEPTH = 2048,
    parameter int WIDTH = 36
) (
    input  logic             rst_n,
    input  logic             mode_std,
    input  logic             wr_clk,
    input  logic             wr_cs_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic             wr_flag,
    input  logic             rd_clk,
    input  logic             rd_cs_n,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_flag
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic          wr_rst_sn, rd_rst_sn;
    logic          wr_fire, rd_fire, wr_push;
    logic [PW-1:0] wr_bin, wr_gray, rd_bin, rd_gray;
    logic [PW-1:0] wgray_in_rd, rgray_in_wr;
    logic [WIDTH-1:0] head_word;
    logic          rd_is_std, rd_mode_known;

    assign wr_fire = !wr_cs_n && wr_en;
    assign rd_fire = !rd_cs_n && rd_en;

    xdom_fifo_rstsync #(.STAGES(2)) u_wrst (
        .clk(wr_clk), .arst_n(rst_n), .srst_n(wr_rst_sn));
    xdom_fifo_rstsync #(.STAGES(2)) u_rrst (
        .clk(rd_clk), .arst_n(rst_n), .srst_n(rd_rst_sn));

    xdom_fifo_gsync #(.W(PW), .STAGES(2)) u_w2r (
        .clk(rd_clk), .rst_n(rd_rst_sn), .d(wr_gray), .q(wgray_in_rd));
    xdom_fifo_gsync #(.W(PW), .STAGES(2)) u_r2w (
        .clk(wr_clk), .rst_n(wr_rst_sn), .d(rd_gray), .q(rgray_in_wr));

    xdom_fifo_ram #(.AW(AW), .WIDTH(WIDTH)) u_ram (
        .wclk(wr_clk), .we(wr_push), .waddr(wr_bin[AW-1:0]), .wdata(wr_data),
        .raddr(rd_bin[AW-1:0]), .rdata(head_word));

    xdom_fifo_wside #(.AW(AW)) u_wside (
        .clk(wr_clk), .rst_n(wr_rst_sn), .fire(wr_fire), .rgray_s(rgray_in_wr),
        .push(wr_push), .wbin(wr_bin), .wgray(wr_gray), .wr_ok(wr_flag));

    xdom_fifo_rside #(.AW(AW), .WIDTH(WIDTH)) u_rside (
        .clk(rd_clk), .rst_n(rd_rst_sn), .mode_std(mode_std), .fire(rd_fire),
        .wgray_s(wgray_in_rd), .head_word(head_word), .rbin(rd_bin),
        .rgray(rd_gray), .rd_data(rd_data), .rd_ok(rd_flag),
        .is_std(rd_is_std), .mode_known(rd_mode_known));
endmodule

// File: rtl/xdom_fifo_chk.sv
module xdom_fifo_chk #(
    parameter int AW    = 11,
    parameter int WIDTH = 36
) (
    input logic             wr_clk,
    input logic             rd_clk,
    input logic             wr_rst_sn,
    input logic             rd_rst_sn,
    input logic             wr_cs_n,
    input logic             wr_en,
    input logic             rd_cs_n,
    input logic             rd_en,
    input logic             wr_flag,
    input logic             rd_flag,
    input logic [WIDTH-1:0] rd_data,
    input logic [AW:0]      wr_bin,
    input logic [AW:0]      rd_bin,
    input logic             rd_is_std,
    input logic             rd_mode_known
);
    logic wfire, rfire;
    assign wfire = !wr_cs_n && wr_en;
    assign rfire = !rd_cs_n && rd_en;

    AST_WR_GATED: assert property (@(posedge wr_clk) disable iff (!wr_rst_sn)
        !wfire |=> $stable(wr_bin)); // R1

    AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!wr_rst_sn)
        (wfire && !wr_flag) |=> $stable(wr_bin)); // R8

    AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (!rd_rst_sn)
        (rd_is_std && rfire && !rd_flag) |=> ($stable(rd_bin) && $stable(rd_data))); // R9

    AST_STD_HOLD: assert property (@(posedge rd_clk) disable iff (!rd_rst_sn)
        (rd_is_std && !(rfire && rd_flag)) |=> $stable(rd_data)); // R6

    AST_FT_PRESENT: assert property (@(posedge rd_clk) disable iff (!rd_rst_sn)
        (rd_mode_known && !rd_is_std && rd_flag && !rfire) |=> (rd_flag && $stable(rd_data))); // R5

    AST_MODE_FIXED: assert property (@(posedge rd_clk) disable iff (!rd_rst_sn)
        rd_mode_known |=> (rd_mode_known && $stable(rd_is_std))); // R4

    AST_RD_STEP: assert property (@(posedge rd_clk) disable iff (!rd_rst_sn)
        (rd_bin == $past(rd_bin)) || (rd_bin == $past(rd_bin) + 1'b1)); // R7
endmodule

bind xdom_fifo xdom_fifo_chk #(.AW(AW), .WIDTH(WIDTH)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_rst_sn(wr_rst_sn), .rd_rst_sn(rd_rst_sn),
    .wr_cs_n(wr_cs_n), .wr_en(wr_en), .rd_cs_n(rd_cs_n), .rd_en(rd_en),
    .wr_flag(wr_flag), .rd_flag(rd_flag), .rd_data(rd_data),
    .wr_bin(wr_bin), .rd_bin(rd_bin), .rd_is_std(rd_is_std),
    .rd_mode_known(rd_mode_known));

// File: tb/xdom_fifo_tb.sv
module xdom_fifo_tb;
    localparam int WR_PERIOD = 10;
    localparam int RD_PERIOD = 14;
    localparam int DEPTH     = 16;
    localparam int WIDTH     = 36;

    logic rst_n = 1'b0, mode_std = 1'b1;
    logic wr_clk = 1'b0, rd_clk = 1'b0;
    logic wr_cs_n = 1'b1, wr_en = 1'b0, rd_cs_n = 1'b1, rd_en = 1'b0;
    logic [WIDTH-1:0] wr_data = '0;
    logic [WIDTH-1:0] rd_data;
    logic wr_flag, rd_flag;
    int total = 0, bad = 0;

    always #(WR_PERIOD/2) wr_clk = ~wr_clk;
    always #(RD_PERIOD/2) rd_clk = ~rd_clk;

    xdom_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dut (
        .rst_n(rst_n), .mode_std(mode_std),
        .wr_clk(wr_clk), .wr_cs_n(wr_cs_n), .wr_en(wr_en), .wr_data(wr_data), .wr_flag(wr_flag),
        .rd_clk(rd_clk), .rd_cs_n(rd_cs_n), .rd_en(rd_en), .rd_data(rd_data), .rd_flag(rd_flag));

    // {mode_std, word count, data tag}
    localparam logic [13:0] VEC [0:5] = '{
        {1'b1, 5'd1,  8'h11},
        {1'b1, 5'd5,  8'h22},
        {1'b0, 5'd1,  8'h33},
        {1'b0, 5'd7,  8'h44},
        {1'b1, 5'd0,  8'h55},
        {1'b0, 5'd12, 8'h66}
    };

    function automatic logic [WIDTH-1:0] mkw(input logic [7:0] tag, input int i);
        return {20'hC3A5F, tag, 8'(i)};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [WIDTH-1:0] act,
                       input logic [WIDTH-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge rd_clk);
        repeat (8) @(negedge wr_clk);
        @(negedge rd_clk);
    endtask

    task automatic do_reset(input logic m);
        rst_n = 1'b0;
        mode_std = m;
        repeat (3) @(negedge rd_clk);
        rst_n = 1'b1;
        repeat (6) @(negedge rd_clk);
        @(negedge wr_clk);
    endtask

    task automatic push(input logic [WIDTH-1:0] d);
        @(negedge wr_clk);
        wr_cs_n = 1'b0; wr_en = 1'b1; wr_data = d;
        @(negedge wr_clk);
        wr_cs_n = 1'b1; wr_en = 1'b0;
    endtask

    task automatic rd_pulse();
        rd_cs_n = 1'b0; rd_en = 1'b1;
        @(negedge rd_clk);
        rd_cs_n = 1'b1; rd_en = 1'b0;
    endtask

    task automatic pop_check(input logic m, input logic [WIDTH-1:0] exp, input string req);
        @(negedge rd_clk);
        chk(rd_flag == 1'b1, req, 36'(rd_flag), 36'd1);
        if (m) begin
            rd_pulse();
            chk(rd_data == exp, req, rd_data, exp);
        end else begin
            chk(rd_data == exp, req, rd_data, exp);
            rd_pulse();
        end
    endtask

    initial begin
        logic [WIDTH-1:0] held;

        // R11: reset state
        rst_n = 1'b0;
        repeat (3) @(negedge rd_clk);
        chk(wr_flag == 1'b0, "R11", 36'(wr_flag), 36'd0);
        chk(rd_flag == 1'b0, "R11", 36'(rd_flag), 36'd0);
        chk(rd_data == '0, "R11", rd_data, '0);

        // vector walk: R3 R5 R6 R7
        for (int v = 0; v < 6; v++) begin
            logic       m;
            int         n;
            logic [7:0] tg;
            m  = VEC[v][13];
            n  = int'(VEC[v][12:8]);
            tg = VEC[v][7:0];
            do_reset(m);
            chk(wr_flag == 1'b1, "R2", 36'(wr_flag), 36'd1);
            for (int i = 0; i < n; i++) push(mkw(tg, i));
            settle();
            chk(rd_flag == (n > 0), m ? "R3" : "R5", 36'(rd_flag), 36'(n > 0));
            for (int i = 0; i < n; i++) pop_check(m, mkw(tg, i), m ? "R6 R7" : "R5 R7");
            settle();
            chk(rd_flag == 1'b0, m ? "R3" : "R5", 36'(rd_flag), 36'd0);
        end

        // R10 / R8: standard capacity, overflow ignored
        do_reset(1'b1);
        for (int i = 0; i < DEPTH; i++) push(mkw(8'hA0, i));
        settle();
        chk(wr_flag == 1'b0, "R10", 36'(wr_flag), 36'd0);
        push(mkw(8'hEE, 0));
        settle();
        for (int i = 0; i < DEPTH; i++) pop_check(1'b1, mkw(8'hA0, i), "R8");
        settle();
        chk(rd_flag == 1'b0, "R8", 36'(rd_flag), 36'd0);

        // R10: fall-through holds one more
        do_reset(1'b0);
        for (int i = 0; i < DEPTH; i++) push(mkw(8'hB0, i));
        settle();
        chk(wr_flag == 1'b1, "R10", 36'(wr_flag), 36'd1);
        push(mkw(8'hB0, DEPTH));
        settle();
        chk(wr_flag == 1'b0, "R10", 36'(wr_flag), 36'd0);
        for (int i = 0; i <= DEPTH; i++) pop_check(1'b0, mkw(8'hB0, i), "R10");

        // R1: gated transfers
        do_reset(1'b1);
        @(negedge wr_clk);
        wr_cs_n = 1'b1; wr_en = 1'b1; wr_data = mkw(8'hC0, 1);
        @(negedge wr_clk);
        wr_cs_n = 1'b0; wr_en = 1'b0;
        @(negedge wr_clk);
        wr_cs_n = 1'b1;
        settle();
        chk(rd_flag == 1'b0, "R1", 36'(rd_flag), 36'd0);
        push(mkw(8'hC0, 2));
        settle();
        held = rd_data;
        rd_cs_n = 1'b1; rd_en = 1'b1;
        @(negedge rd_clk);
        rd_en = 1'b0; rd_cs_n = 1'b0;
        @(negedge rd_clk);
        rd_cs_n = 1'b1;
        chk(rd_flag == 1'b1, "R1", 36'(rd_flag), 36'd1);
        chk(rd_data == held, "R1", rd_data, held);
        pop_check(1'b1, mkw(8'hC0, 2), "R1");

        // R9: read on empty ignored
        do_reset(1'b1);
        held = rd_data;
        @(negedge rd_clk);
        rd_pulse();
        chk(rd_data == held, "R9", rd_data, held);
        push(mkw(8'hD0, 7));
        settle();
        pop_check(1'b1, mkw(8'hD0, 7), "R9");

        // R4: mode pin changes after capture are ignored
        do_reset(1'b0);
        mode_std = 1'b1;
        push(mkw(8'hE0, 3));
        settle();
        chk(rd_flag == 1'b1, "R4", 36'(rd_flag), 36'd1);
        chk(rd_data == mkw(8'hE0, 3), "R4", rd_data, mkw(8'hE0, 3));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge wr_clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule